// File: doc/BRIEF.md
# Bidirectional I/O Port Register File

This block is a sixteen-entry byte register file on a halfword-aligned bus. It holds the state of three bidirectional controller ports. Each port has a data byte and a direction byte. Direction bits that are set mark a pin as driven by the block. Clear bits leave the pin to the attached device, and a weak pull-up holds such a pin high. The top pin of every port is always driven.

Reading a port slot returns a merged byte. Driven pins show the stored data bit and undriven pins show the device's returned bit. Entry zero returns a fixed version code. Every entry that is neither entry zero nor a port slot is plain byte storage.

The block presents to each device the byte the device sees on its pins, and it breaks out the select pin (bit 6) as its own signal. On the first two ports it raises a one-cycle flag during any write that takes the select pin from low to high. The attached pad uses that flag to advance its own state.

Top module: `ioport_regfile`

## Requirements
- R1: After reset every data and direction byte is 0x00, so each port presents 0x7F to its device and entries 4 to 15 read 0x00.
- R2: The entry index is bus_addr[4:1]. bus_addr[0] has no effect on reads or writes.
- R3: Entry 0 always reads the VERSION parameter (default 0xA5). Writes to entry 0 do not change what it reads.
- R4: Entries 4 to 15 read back the last byte written to them. Entries 4, 5 and 6 are the direction bytes of ports 1, 2 and 3, which sit at entries 1, 2 and 3.
- R5: A port's effective direction mask is its direction byte with bit 7 forced to 1, so bit 7 of a port read always equals bit 7 of its data byte.
- R6: The byte presented to a device is (data AND mask) OR (0x7F AND NOT mask). An undriven pin among bits 0 to 6 presents 1.
- R7: A port read at entries 1 to 3 returns (device byte AND NOT mask) OR (data AND mask).
- R8: dev_th[p] equals bit 6 of the byte presented to port p.
- R9: th_rise[p] is high during the write cycle for ports 1 and 2 only, when the write targets that port's data entry, the stored bit 6 is 0 and the written bit 6 is 1. th_rise is never high for port 3.
- R10: A write with bus_wr_en high lands at the next rising clock edge. With bus_wr_en low, no entry changes.
- R11: bus_rdata is combinational from the current address, the stored state and the device bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte address; bits 4:1 select the entry |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte for the addressed entry |
| dev_in | input | 24 | Byte returned by each device, port p at bits 8p+7:8p |
| dev_drive | output | 24 | Byte presented to each device, same packing |
| dev_th | output | 3 | Select-pin level per port |
| th_rise | output | 3 | Rising select-pin write flag per port |

## Verification
The read byte, the presented bytes and the select levels are combinational. They are sampled one time unit after the inputs change at the falling edge, so they fall in the same cycle as the stimulus. th_rise also depends only on the present write and the stored bit, so it is checked in the write's own cycle before the edge. A write becomes visible only after the next rising edge. The bench model updates its copy of the entry at that edge, and the next read is sampled in the following low phase, which catches any write that lands early, late or not at all.

// File: rtl/ioport_pkg.sv
package ioport_pkg;
   localparam int unsigned PORT_W = 8;
   typedef logic [PORT_W-1:0] port_byte_t;

   function automatic port_byte_t force_msb(input port_byte_t dir);
      return dir | {1'b1, {(PORT_W-1){1'b0}}};
   endfunction

   function automatic port_byte_t low_pullups();
      return {1'b0, {(PORT_W-1){1'b1}}};
   endfunction
endpackage

// File: rtl/ioport_regs.sv
module ioport_regs #(
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned NUM_REGS = 1 << IDX_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [IDX_W-1:0]             wr_idx,
   input  logic [DATA_W-1:0]            wr_data,
   output logic [NUM_REGS*DATA_W-1:0]   regs_o
);
   logic [DATA_W-1:0] mem [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n)
            mem[i] <= '0;
         else if (wr_en && wr_idx == IDX_W'(i))
            mem[i] <= wr_data;
      end
      assign regs_o[i*DATA_W +: DATA_W] = mem[i];
   end

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> mem[$past(wr_idx)] == $past(wr_data));            // R10
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(regs_o));                                 // R10
endmodule

// File: rtl/ioport_pin.sv
module ioport_pin
   import ioport_pkg::*;
#(
   parameter int unsigned TH_BIT = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  port_byte_t data_i,
   input  port_byte_t dir_i,
   input  port_byte_t dev_i,
   output port_byte_t drive_o,
   output port_byte_t read_o,
   output logic       th_o
);
   port_byte_t mask;

   always_comb begin
      mask    = force_msb(dir_i);
      drive_o = (data_i & mask) | (low_pullups() & ~mask);
      read_o  = (dev_i & ~mask) | (data_i & mask);
      th_o    = drive_o[TH_BIT];
   end

   AST_MSB_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      read_o[PORT_W-1] == data_i[PORT_W-1]);                       // R5
   AST_PULLUP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ((drive_o | dir_i) & low_pullups()) == low_pullups());       // R6
   AST_INPUT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      ((read_o ^ dev_i) & ~dir_i & low_pullups()) == '0);          // R7
endmodule

// File: rtl/ioport_th_edge.sv
module ioport_th_edge #(
   parameter int unsigned NUM_PORTS  = 3,
   parameter int unsigned EDGE_PORTS = 2,
   parameter int unsigned IDX_W      = 4,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned TH_BIT     = 6
) (
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      wr_idx,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic [EDGE_PORTS-1:0] old_th,
   output logic [NUM_PORTS-1:0]  rise_o
);
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      if (p < EDGE_PORTS) begin : g_edge
         assign rise_o[p] = wr_en && (wr_idx == IDX_W'(p + 1))
                            && !old_th[p] && wr_data[TH_BIT];
      end else begin : g_none
         assign rise_o[p] = 1'b0;
      end
   end
endmodule

// File: rtl/ioport_regfile.sv
module ioport_regfile
   import ioport_pkg::*;
#(
   parameter int unsigned NUM_PORTS  = 3,
   parameter int unsigned EDGE_PORTS = 2,
   parameter int unsigned IDX_W      = 4,
   parameter int unsigned TH_BIT     = 6,
   parameter logic [7:0]  VERSION    = 8'hA5,
   localparam int unsigned ADDR_W   = IDX_W + 1,
   localparam int unsigned NUM_REGS = 1 << IDX_W,
   localparam int unsigned DIR_OFS  = NUM_PORTS
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic                     bus_wr_en,
   input  logic [PORT_W-1:0]        bus_wdata,
   output logic [PORT_W-1:0]        bus_rdata,
   input  logic [NUM_PORTS*PORT_W-1:0] dev_in,
   output logic [NUM_PORTS*PORT_W-1:0] dev_drive,
   output logic [NUM_PORTS-1:0]     dev_th,
   output logic [NUM_PORTS-1:0]     th_rise
);
   initial begin
      assert (EDGE_PORTS <= NUM_PORTS) else $error("edge ports exceed ports");
      assert (2 * NUM_PORTS + 1 <= NUM_REGS) else $error("too few entries");
      assert (TH_BIT < PORT_W - 1) else $error("select bit out of range");
   end

   logic [IDX_W-1:0]               idx;
   logic                           unused_addr_lsb;
   logic [NUM_REGS*PORT_W-1:0]     regs;
   port_byte_t                     port_rd [NUM_PORTS];
   logic [EDGE_PORTS-1:0]          old_th;
   port_byte_t                     unused_entry0;

   assign idx             = bus_addr[ADDR_W-1:1];
   assign unused_addr_lsb = bus_addr[0];
   assign unused_entry0   = regs[PORT_W-1:0];

   ioport_regs #(.IDX_W(IDX_W), .DATA_W(PORT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .wr_idx(idx),
      .wr_data(bus_wdata), .regs_o(regs));

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      ioport_pin #(.TH_BIT(TH_BIT)) u_pin (
         .clk(clk), .rst_n(rst_n),
         .data_i(regs[(p + 1) * PORT_W +: PORT_W]),
         .dir_i (regs[(p + 1 + DIR_OFS) * PORT_W +: PORT_W]),
         .dev_i (dev_in[p * PORT_W +: PORT_W]),
         .drive_o(dev_drive[p * PORT_W +: PORT_W]),
         .read_o(port_rd[p]),
         .th_o(dev_th[p]));
   end

   for (genvar p = 0; p < EDGE_PORTS; p++) begin : g_old
      assign old_th[p] = regs[(p + 1) * PORT_W + TH_BIT];
   end

   ioport_th_edge #(.NUM_PORTS(NUM_PORTS), .EDGE_PORTS(EDGE_PORTS),
      .IDX_W(IDX_W), .DATA_W(PORT_W), .TH_BIT(TH_BIT)) u_edge (
      .wr_en(bus_wr_en), .wr_idx(idx), .wr_data(bus_wdata),
      .old_th(old_th), .rise_o(th_rise));

   always_comb begin
      bus_rdata = regs[idx * PORT_W +: PORT_W];
      for (int p = 0; p < NUM_PORTS; p++)
         if (idx == IDX_W'(p + 1)) bus_rdata = port_rd[p];
      if (idx == '0) bus_rdata = VERSION;
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
      AST_RISE_THEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
         th_rise[p] |=> dev_th[p]);                                // R9
   end
   AST_VERSION_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (idx == '0) |-> bus_rdata == VERSION);                       // R3
   AST_LAST_PORT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      !th_rise[NUM_PORTS-1]);                                      // R9
endmodule

// File: tb/ioport_regfile_test.sv
module ioport_regfile_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr_en = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [23:0] dev_in = '0;
   logic [23:0] dev_drive;
   logic [2:0]  dev_th;
   logic [2:0]  th_rise;

   int tests = 0;
   int fails = 0;
   logic [7:0] model [16];

   ioport_regfile uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
      .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .dev_in(dev_in), .dev_drive(dev_drive), .dev_th(dev_th), .th_rise(th_rise));

   always #2 clk = ~clk;

   function automatic logic [7:0] msk(int p);
      return model[4 + p] | 8'h80;
   endfunction
   function automatic logic [7:0] exp_drive(int p);
      return (model[1 + p] & msk(p)) | (8'h7F & ~msk(p));
   endfunction
   function automatic logic [7:0] exp_read(logic [3:0] i);
      if (i == 0) return 8'hA5;
      if (i >= 1 && i <= 3)
         return (dev_in[(i - 1) * 8 +: 8] & ~msk(i - 1)) | (model[i] & msk(i - 1));
      return model[i];
   endfunction

   task automatic chk(logic [7:0] act, logic [7:0] exp, string req);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic chk_ports(string req);
      for (int p = 0; p < 3; p++) begin
         chk(dev_drive[p * 8 +: 8], exp_drive(p), {req, " R6 drive"});
         chk({7'd0, dev_th[p]}, {7'd0, exp_drive(p)[6]}, {req, " R8 th"});
      end
   endtask

   task automatic do_write(logic [4:0] a, logic [7:0] d);
      logic [3:0] i;
      logic [2:0] er;
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
      i = a[4:1];
      #1;
      for (int p = 0; p < 3; p++)
         er[p] = (p < 2) && (i == 4'(p + 1)) && !model[p + 1][6] && d[6];
      chk({5'd0, th_rise}, {5'd0, er}, "R9 rise flag");
      @(posedge clk);
      model[i] = d;
   endtask

   task automatic do_read(logic [4:0] a, string req);
      @(negedge clk);
      bus_addr = a; bus_wr_en = 1'b0;
      #1;
      chk(bus_rdata, exp_read(a[4:1]), req);
   endtask

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < 16; i++) model[i] = 8'h00;
      dev_in = 24'h3C_A5_5A;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1 reset state
      #1; chk_ports("R1 reset");
      for (int i = 4; i < 16; i++) do_read(5'(i * 2), "R1 reset entry");
      do_read(5'd2, "R1 R7 reset port read");
      // R3 version and write to entry 0
      do_read(5'd0, "R3 version");
      do_write(5'd0, 8'h11);
      do_read(5'd0, "R3 write ignored");
      // R2 address bit 0 ignored
      do_write(5'd15, 8'h6D);
      do_read(5'd14, "R2 lsb ignored");
      do_read(5'd15, "R4 storage readback");
      // R5 bit 7 always driven, R7 merge
      do_write(5'd8, 8'h00);
      do_write(5'd2, 8'h80);
      dev_in[7:0] = 8'h00;
      do_read(5'd2, "R5 msb from data");
      dev_in[7:0] = 8'hFF;
      do_write(5'd2, 8'h00);
      do_read(5'd2, "R5 msb not from device");
      chk_ports("R6 pullups");
      // R9 rise on port 1, then no rise when already high
      do_write(5'd2, 8'h40);
      do_write(5'd2, 8'h40);
      do_write(5'd2, 8'h00);
      // port 3 never flags
      do_write(5'd6, 8'h40);
      // R10 no write when strobe low
      @(negedge clk);
      bus_addr = 5'd20; bus_wdata = 8'hEE; bus_wr_en = 1'b0;
      @(posedge clk);
      do_read(5'd20, "R10 idle strobe");
      // random mix
      for (int n = 0; n < 600; n++) begin
         logic [4:0] a;
         a = 5'($urandom);
         dev_in = 24'($urandom);
         if ($urandom % 2 == 0) do_write(a, 8'($urandom));
         else begin
            do_read(a, "R7 R11 random read");
            chk_ports("R6 random");
         end
      end
      bus_wr_en = 1'b0;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule